// File: doc/BRIEF.md
# Turbo Decoder Stop Controller with Hard-Decision Signature

This block tells an iterative turbo decoder when further iterations are pointless. The component decoder streams its a-posteriori soft values into the block, one value per cycle, each qualified by a valid flag. The block slices every value to a hard bit and folds the bits of a half-iteration into a 16-bit signature held in a feedback shift register. The signature is a compact stand-in for the full list of decisions. When a half-iteration processed in natural order closes, the block compares the signature with the one kept from the previous natural-order half-iteration. If the two are equal, the decisions have settled and the block requests a stop.

An iteration ceiling caps the work on code blocks that never settle. The ceiling is counted in half-iterations, so a limit such as seven and a half iterations can be set. The decoder marks each half-iteration with start and end strobes and a flag that says whether it runs in natural or interleaved order. It also strobes a block-start line whenever a new code block begins. The block reports the number of completed half-iterations, holds a stop request, and gives a one-cycle done pulse when the decision is made.

Top module: `turbo_hash_stop`

## Requirements
- R1: After reset, `stop_req` and `done_pulse` are 0 and `half_count` is 0.
- R2: The hard bit of a soft value is its sign bit, so a negative value gives 1. At a start strobe with `hi_natural`=1 the signature is loaded with 0xFFFF. Each valid value then updates it as next = {h[14:0],0} XOR (0x1021 if h[15] XOR bit else 0). The update starts from the seed when the value arrives in the same cycle as the seed load.
- R3: At an end strobe with `hi_natural`=1, if the signature equals a valid saved signature, then `stop_req` rises and `done_pulse` fires in the cycle after the strobe. `done_pulse` never fires without an end strobe.
- R4: At the first natural-order end strobe after `blk_start`, no stop occurs on a signature match, even when the signature equals the one saved in the previous code block.
- R5: An end strobe with `hi_natural`=0 neither compares the signatures nor replaces the saved signature.
- R6: While `stop_req` is 0, each end strobe raises `half_count` by one, visible in the following cycle.
- R7: When `half_count` reaches `max_half` at an end strobe, the block stops even without a match. A value of 15 means 7.5 iterations.
- R8: `done_pulse` lasts one cycle. `stop_req` stays high, and strobes and data have no effect on the outputs, until the next `blk_start`.
- R9: `blk_start` clears `stop_req`, `done_pulse` and `half_count`, and invalidates the saved signature. It has priority over all other inputs in the same cycle.
- R10: A cycle with `soft_vld`=0 leaves the signature unchanged, whatever `soft_llr` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| blk_start | input | 1 | New code block begins |
| hi_start | input | 1 | Half-iteration start strobe |
| hi_end | input | 1 | Half-iteration end strobe |
| hi_natural | input | 1 | Current half-iteration runs in natural order |
| soft_vld | input | 1 | Qualifies `soft_llr` |
| soft_llr | input | LLR_W | Signed a-posteriori soft value |
| max_half | input | CNT_W | Iteration ceiling in half-iterations |
| stop_req | output | 1 | Stop request, held until the next block |
| done_pulse | output | 1 | One-cycle pulse when the stop decision is made |
| half_count | output | CNT_W | Completed half-iterations in this block |

## Verification
The bench builds the block with its default parameters: 6-bit soft values, a 16-bit signature with feedback 0x1021, and a 5-bit counter. With a 5-bit counter, ceilings from 1 up to 31 half-iterations can be set. Together these cover a match at the earliest legal check, stops forced by the ceiling on both odd and even half-counts, and the directed ceiling of 15. Repeating identical frames across consecutive code blocks puts a stale saved signature within reach, and feeding identical data into interleaved half-iterations does the same for a false comparison on an interleaved half-iteration.

// File: rtl/hstop_pkg.sv
package hstop_pkg;

   typedef enum logic {
      CONV_NEG_IS_ONE = 1'b0,
      CONV_POS_IS_ONE = 1'b1
   } sign_conv_e;

   localparam int unsigned DEF_HASH_W = 16;
   localparam logic [DEF_HASH_W-1:0] DEF_POLY = 16'h1021;

endpackage

// File: rtl/hstop_slicer.sv
module hstop_slicer
   import hstop_pkg::*;
#(
   parameter int unsigned LLR_W = 6,
   parameter sign_conv_e  CONV  = CONV_NEG_IS_ONE
) (
   input  logic [LLR_W-1:0] llr,
   output logic             hard
);
   localparam int unsigned SIGN_B = LLR_W - 1;

   logic nonzero;
   assign nonzero = |llr;

   generate
      if (CONV == CONV_NEG_IS_ONE) begin : g_neg
         assign hard = llr[SIGN_B] & nonzero;
      end else begin : g_pos
         assign hard = ~llr[SIGN_B] & nonzero;
      end
   endgenerate
endmodule

// File: rtl/hstop_sig.sv
module hstop_sig #(
   parameter int unsigned       HASH_W = 16,
   parameter logic [HASH_W-1:0] POLY   = 16'h1021,
   parameter logic [HASH_W-1:0] SEED   = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              seed_load,
   input  logic              shift_en,
   input  logic              bit_in,
   output logic [HASH_W-1:0] sig
);
   localparam int unsigned TOP = HASH_W - 1;

   logic [HASH_W-1:0] base;
   logic [HASH_W-1:0] stepped;
   logic              fb;

   always_comb begin
      base    = seed_load ? SEED : sig;
      fb      = base[TOP] ^ bit_in;
      stepped = {base[TOP-1:0], 1'b0} ^ ({HASH_W{fb}} & POLY);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sig <= SEED;
      else if (shift_en) sig <= stepped;
      else               sig <= base;
   end
endmodule

// File: rtl/hstop_judge.sv
module hstop_judge #(
   parameter int unsigned HASH_W = 16,
   parameter int unsigned CNT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              blk_start,
   input  logic              hi_end,
   input  logic              hi_natural,
   input  logic [HASH_W-1:0] sig,
   input  logic [CNT_W-1:0]  max_half,
   output logic              stop_req,
   output logic              done_pulse,
   output logic [CNT_W-1:0]  half_count
);
   logic [HASH_W-1:0] saved_sig;
   logic              saved_ok;
   logic [CNT_W-1:0]  cnt_next;
   logic              end_live;
   logic              match;
   logic              at_limit;

   always_comb begin
      cnt_next = half_count + 1'b1;
      end_live = hi_end & ~stop_req;
      match    = hi_natural & saved_ok & (sig == saved_sig);
      at_limit = cnt_next >= max_half;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         saved_sig  <= '0;
         saved_ok   <= 1'b0;
         half_count <= '0;
         stop_req   <= 1'b0;
         done_pulse <= 1'b0;
      end else if (blk_start) begin
         saved_ok   <= 1'b0;
         half_count <= '0;
         stop_req   <= 1'b0;
         done_pulse <= 1'b0;
      end else begin
         done_pulse <= 1'b0;
         if (end_live) begin
            half_count <= cnt_next;
            if (hi_natural) begin
               saved_sig <= sig;
               saved_ok  <= 1'b1;
            end
            if (match || at_limit) begin
               stop_req   <= 1'b1;
               done_pulse <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/turbo_hash_stop.sv
module turbo_hash_stop
   import hstop_pkg::*;
#(
   parameter int unsigned       LLR_W  = 6,
   parameter int unsigned       HASH_W = DEF_HASH_W,
   parameter logic [HASH_W-1:0] POLY   = DEF_POLY,
   parameter int unsigned       CNT_W  = 5,
   parameter sign_conv_e        CONV   = CONV_NEG_IS_ONE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             blk_start,
   input  logic             hi_start,
   input  logic             hi_end,
   input  logic             hi_natural,
   input  logic             soft_vld,
   input  logic [LLR_W-1:0] soft_llr,
   input  logic [CNT_W-1:0] max_half,
   output logic             stop_req,
   output logic             done_pulse,
   output logic [CNT_W-1:0] half_count
);
   localparam logic [HASH_W-1:0] SEED = '1;

   generate
      if (HASH_W < 2) begin : g_bad_hash
         $error("HASH_W must be at least 2");
      end
      if (POLY[0] != 1'b1) begin : g_bad_poly
         $error("POLY must include the constant term");
      end
      if (LLR_W < 2) begin : g_bad_llr
         $error("LLR_W must be at least 2");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W must be at least 2");
      end
   endgenerate

   logic              hard_bit;
   logic [HASH_W-1:0] sig;

   hstop_slicer #(.LLR_W(LLR_W), .CONV(CONV)) i_slicer (
      .llr  (soft_llr),
      .hard (hard_bit)
   );

   hstop_sig #(.HASH_W(HASH_W), .POLY(POLY), .SEED(SEED)) i_sig (
      .clk       (clk),
      .rst_n     (rst_n),
      .seed_load (hi_start & hi_natural),
      .shift_en  (soft_vld),
      .bit_in    (hard_bit),
      .sig       (sig)
   );

   hstop_judge #(.HASH_W(HASH_W), .CNT_W(CNT_W)) i_judge (
      .clk        (clk),
      .rst_n      (rst_n),
      .blk_start  (blk_start),
      .hi_end     (hi_end),
      .hi_natural (hi_natural),
      .sig        (sig),
      .max_half   (max_half),
      .stop_req   (stop_req),
      .done_pulse (done_pulse),
      .half_count (half_count)
   );
endmodule

// File: rtl/hstop_checker.sv
module hstop_checker #(
   parameter int unsigned CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             blk_start,
   input logic             hi_end,
   input logic             hi_natural,
   input logic [CNT_W-1:0] max_half,
   input logic             stop_req,
   input logic             done_pulse,
   input logic [CNT_W-1:0] half_count
);
   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |=> !done_pulse);

   p_done_has_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |-> stop_req);

   p_frozen_after_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_req && !blk_start) |=> (stop_req && $stable(half_count)));

   p_block_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      blk_start |=> (!stop_req && !done_pulse && half_count == '0));

   p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_end && !stop_req && !blk_start) |=> (half_count == $past(half_count) + 1'b1));

   p_interleaved_no_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_end && !hi_natural && !stop_req && !blk_start &&
       ({1'b0, half_count} + 1'b1 < {1'b0, max_half})) |=> !done_pulse);

   p_done_needs_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((!hi_end || stop_req) && !blk_start) |=> !done_pulse);
endmodule

bind turbo_hash_stop hstop_checker #(.CNT_W(CNT_W)) i_hstop_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .blk_start  (blk_start),
   .hi_end     (hi_end),
   .hi_natural (hi_natural),
   .max_half   (max_half),
   .stop_req   (stop_req),
   .done_pulse (done_pulse),
   .half_count (half_count)
);

// File: tb/test_turbo_hash_stop.sv
module test_turbo_hash_stop;
   localparam int CLK_P  = 10;
   localparam int LLR_W  = 6;
   localparam int CNT_W  = 5;
   localparam int WDOG   = 150000;
   localparam logic [15:0] POLY = 16'h1021;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic b_blk = 0, b_hs = 0, b_he = 0, b_nat = 0, b_vld = 0;
   logic [LLR_W-1:0] b_llr = '0;
   logic [CNT_W-1:0] b_max = 5'd10;
   logic stop_req, done_pulse;
   logic [CNT_W-1:0] half_count;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   logic [15:0] m_hash = 16'hFFFF, m_saved = '0;
   logic        m_sv = 0, m_stop = 0, m_done = 0;
   logic [CNT_W-1:0] m_cnt = '0;
   logic [LLR_W-1:0] stable_frm [64];

   always #(CLK_P/2) clk = ~clk;

   turbo_hash_stop i_turbo_hash_stop (
      .clk(clk), .rst_n(rst_n), .blk_start(b_blk), .hi_start(b_hs),
      .hi_end(b_he), .hi_natural(b_nat), .soft_vld(b_vld), .soft_llr(b_llr),
      .max_half(b_max), .stop_req(stop_req), .done_pulse(done_pulse),
      .half_count(half_count));

   function automatic logic [15:0] sig_step(logic [15:0] h, logic b);
      logic fb = h[15] ^ b;
      return {h[14:0], 1'b0} ^ (fb ? POLY : 16'h0000);
   endfunction

   task automatic chk(string tag);
      checks++;
      if (stop_req !== m_stop || done_pulse !== m_done || half_count !== m_cnt) begin
         errors++;
         $display("FAIL %s: stop/done/count actual %b/%b/%0d expected %b/%b/%0d",
                  tag, stop_req, done_pulse, half_count, m_stop, m_done, m_cnt);
      end
   endtask

   // model update from the inputs seen at this edge
   task automatic model();
      logic [15:0] base;
      logic [CNT_W-1:0] nc;
      logic hit;
      if (b_blk) begin
         m_cnt = '0; m_sv = 0; m_stop = 0; m_done = 0;
         if (b_vld) m_hash = sig_step(b_hs && b_nat ? 16'hFFFF : m_hash, b_llr[LLR_W-1] & (|b_llr));
         else if (b_hs && b_nat) m_hash = 16'hFFFF;
         return;
      end
      m_done = 0;
      base = (b_hs && b_nat) ? 16'hFFFF : m_hash;
      if (b_he && !m_stop) begin
         nc  = m_cnt + 1'b1;
         hit = b_nat && m_sv && (m_hash == m_saved);
         if (b_nat) begin m_saved = m_hash; m_sv = 1; end
         m_cnt = nc;
         if (hit || nc >= b_max) begin m_stop = 1; m_done = 1; end
      end
      m_hash = b_vld ? sig_step(base, b_llr[LLR_W-1] & (|b_llr)) : base;
   endtask

   task automatic tick(string tag);
      @(posedge clk);
      model();
      cycles++;
      @(negedge clk);
      chk(tag);
      b_blk = 0; b_hs = 0; b_he = 0; b_vld = 0;
      b_llr = LLR_W'($urandom);
   endtask

   task automatic run_half(logic nat, logic use_stable, int len);
      b_nat = nat; b_hs = 1;
      tick("R2");
      for (int i = 0; i < len; i++) begin
         if ($urandom_range(3) == 0) begin
            b_vld = 0; b_llr = LLR_W'($urandom);
            tick("R10");
         end
         b_vld = 1;
         b_llr = use_stable ? stable_frm[i] : LLR_W'($urandom);
         tick("R2");
      end
      b_he = 1;
      if (m_stop) tick("R8");
      else if (nat) tick("R3 R4 R7");
      else tick("R5 R6");
   endtask

   // mode 0: every half identical; 1: all random; 2: random first two natural
   task automatic run_block(int mode, int maxh, int len, logic new_frame);
      int extra = 0;
      if (new_frame)
         for (int i = 0; i < 64; i++) stable_frm[i] = LLR_W'($urandom);
      b_max = CNT_W'(maxh);
      b_blk = 1;
      tick("R9");
      for (int h = 0; h < 40; h++) begin
         logic st = (mode == 0) || (mode == 2 && h >= 4);
         run_half((h % 2) == 0, st, len);
         if (m_stop) begin
            extra++;
            if (extra > 2) break;
         end
      end
   endtask

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'd20240611);
      repeat (3) @(negedge clk);
      chk("R1");
      rst_n = 1;
      @(negedge clk);
      chk("R1");
      // R4: same frame across two blocks; stale saved signature must not stop
      run_block(0, 20, 12, 1);
      run_block(0, 20, 12, 0);
      // R7: ceiling of 15 half-iterations (7.5 iterations) on random data
      run_block(1, 15, 10, 1);
      // R7: ceiling 1 stops at the first end strobe
      run_block(1, 1, 5, 1);
      // R9: block start while in the middle of an active block
      b_max = 5'd20;
      b_blk = 1; tick("R9");
      run_half(1, 0, 6);
      b_blk = 1; tick("R9");
      for (int k = 0; k < 60; k++)
         run_block(int'($urandom_range(2)), int'($urandom_range(31, 1)),
                   int'($urandom_range(40, 1)), 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (WDOG) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", WDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule